// File: doc/BRIEF.md
# Two-Bank Interrupt Controller with Fast/Normal Steering

The block gathers up to 64 level-sensitive interrupt sources and drives two lines toward a processor. One is a normal interrupt request (`irq`); the other is a fast interrupt request (`fiq`). Each source has its own enable bit and its own steering bit. The steering bit chooses which of the two lines the source can raise. The sources are split into two banks of 32, and each bank has its own enable, steering and pending registers.

Thirteen general-purpose pins feed into fixed source numbers in the low bank. On those numbers the pin replaces the peripheral source. Software reads the pending registers to see the raw state of every source, whether or not the source is enabled, and uses the same word interface to program the enable and steering registers. Sources are sampled by one register stage, so a change on a source reaches `irq` and `fiq` one clock later.

Top module: `intc_twobank`

## Requirements
- R1: After reset, both enable registers and both steering registers read 0, and `irq` and `fiq` are low.
- R2: An enable bit of 1 lets a pending source reach its output line. An enable bit of 0 keeps that source off both lines.
- R3: A steering bit of 0 sends its enabled source to `irq`. A steering bit of 1 sends it to `fiq`.
- R4: Word addresses 0, 1 and 2 hold the enable, steering and pending registers for sources 0..31 at bit position s. Addresses 3, 4 and 5 hold the same three registers for sources 32..63 at bit position s-32.
- R5: A pending register shows the sampled source state whether or not the source is enabled. It follows the source one clock after the source changes.
- R6: Writes to addresses 2 and 5 have no effect on what the pending registers read.
- R7: Source 6 is taken from pin 0 and source 7 from pin 1.
- R8: Sources 19..29 are taken from pins 2..12 in order. The peripheral inputs at source numbers 6, 7 and 19..29 have no effect.
- R9: `irq` and `fiq` are computed independently. Each is the OR over all 64 sources of (pending AND enable AND the matching steering value), so both lines can be high at once.
- R10: Addresses 6 and 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 64 | Peripheral interrupt sources, level-sensitive, active high |
| gpio_in | input | 13 | General-purpose pin inputs, mapped onto fixed source numbers |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
The assertions check on every cycle that:
- the pending state is the previous cycle's source sample, whatever was written to it;
- a write to the low-bank enable address lands in that register;
- neither line rises while every enable bit is clear;
- each line is high only while some enabled source is steered to it.

Only the bench scenarios can show the following:
- the pin-to-source map and the bit placement in the high bank;
- the peripheral inputs at pin-mapped numbers having no effect;
- both lines being high together;
- the behaviour of the unused addresses.

// File: rtl/intc_twobank.sv
module intc_twobank #(
  parameter int BANK_W = 32,
  parameter int GPIO_N = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*BANK_W-1:0]   src_in,
  input  logic [GPIO_N-1:0]     gpio_in,
  input  logic                  reg_we,
  input  logic [2:0]            reg_addr,
  input  logic [BANK_W-1:0]     reg_wdata,
  output logic [BANK_W-1:0]     reg_rdata,
  output logic                  irq,
  output logic                  fiq
);
  localparam int NSRC = 2 * BANK_W;

  function automatic int pin_of(input int s);
    if (s == 6 || s == 7) return s - 6;
    if (s >= 19 && s <= 29) return s - 17;
    return -1;
  endfunction

  logic [NSRC-1:0] raw, pend_q, mask_q, steer_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (pin_of(g) >= 0 && pin_of(g) < GPIO_N) begin : g_pin
      assign raw[g] = gpio_in[pin_of(g)];
    end else begin : g_per
      assign raw[g] = src_in[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '0;
      steer_q <= '0;
    end else begin
      pend_q <= raw;
      if (reg_we) begin
        case (reg_addr)
          3'd0: mask_q[BANK_W-1:0]     <= reg_wdata;
          3'd1: steer_q[BANK_W-1:0]    <= reg_wdata;
          3'd3: mask_q[NSRC-1:BANK_W]  <= reg_wdata;
          3'd4: steer_q[NSRC-1:BANK_W] <= reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = mask_q[BANK_W-1:0];
      3'd1: reg_rdata = steer_q[BANK_W-1:0];
      3'd2: reg_rdata = pend_q[BANK_W-1:0];
      3'd3: reg_rdata = mask_q[NSRC-1:BANK_W];
      3'd4: reg_rdata = steer_q[NSRC-1:BANK_W];
      3'd5: reg_rdata = pend_q[NSRC-1:BANK_W];
      default: reg_rdata = '0;
    endcase
  end

  wire [NSRC-1:0] live = pend_q & mask_q;
  assign irq = |(live & ~steer_q);
  assign fiq = |(live & steer_q);

  p_pend_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(raw));
  p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 3'd0) |=> mask_q[BANK_W-1:0] == $past(reg_wdata));
  p_masked_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq && !fiq));
  p_fiq_steered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fiq |-> |(mask_q & steer_q));
  p_irq_unsteered_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(mask_q & ~steer_q));
endmodule

// File: tb/sim_intc_twobank.sv
module sim_intc_twobank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic [12:0] gpio_in = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, fiq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intc_twobank u0 (.clk(clk), .rst_n(rst_n), .src_in(src_in), .gpio_in(gpio_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .fiq(fiq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      if (a != 2) begin
        rd(3'(a), d);
        chk("R1 reg", d, 0);
      end
    end
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 fiq", {31'd0, fiq}, 0);
  endtask

  task automatic t_mask();
    src_in = 64'h1;
    settle();
    chk("R2 masked irq", {31'd0, irq}, 0);
    wr(3'd0, 32'h1);
    chk("R2 enabled irq", {31'd0, irq}, 1);
    wr(3'd0, 32'h0);
    chk("R2 blocked irq", {31'd0, irq}, 0);
    src_in = '0; settle();
  endtask

  task automatic t_steer();
    src_in = 64'h4;
    wr(3'd0, 32'h4);
    settle();
    chk("R3 steer0 irq", {31'd0, irq}, 1);
    chk("R3 steer0 fiq", {31'd0, fiq}, 0);
    wr(3'd1, 32'h4);
    chk("R3 steer1 irq", {31'd0, irq}, 0);
    chk("R3 steer1 fiq", {31'd0, fiq}, 1);
    src_in = 64'h6;
    wr(3'd0, 32'h6);
    settle();
    chk("R9 both irq", {31'd0, irq}, 1);
    chk("R9 both fiq", {31'd0, fiq}, 1);
    wr(3'd0, 0); wr(3'd1, 0); src_in = '0; settle();
  endtask

  task automatic t_bank1();
    logic [31:0] d;
    src_in = 64'h1 << 40;
    wr(3'd3, 32'h1 << 8);
    settle();
    rd(3'd5, d);
    chk("R4 bank1 pend", d, 32'h100);
    rd(3'd2, d);
    chk("R4 bank0 pend", d, 0);
    chk("R4 bank1 irq", {31'd0, irq}, 1);
    wr(3'd4, 32'h1 << 8);
    chk("R4 bank1 fiq", {31'd0, fiq}, 1);
    wr(3'd0, 32'h100);
    chk("R4 bank0 mask no effect", {31'd0, fiq}, 1);
    wr(3'd3, 0);
    chk("R4 bank1 off", {31'd0, fiq}, 0);
    wr(3'd4, 0); wr(3'd0, 0); src_in = '0; settle();
  endtask

  task automatic t_pending();
    logic [31:0] d;
    @(negedge clk);
    src_in = 64'h8000_0001_0000_0010;
    rd(3'd2, d);
    chk("R5 before edge", d, 0);
    @(negedge clk);
    rd(3'd2, d);
    chk("R5 low pend", d, 32'h10);
    rd(3'd5, d);
    chk("R5 high pend", d, 32'h8000_0001);
    wr(3'd2, 32'h0);
    rd(3'd2, d);
    chk("R6 pend write", d, 32'h10);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d);
    chk("R6 pend write hi", d, 32'h8000_0001);
    src_in = '0; settle();
  endtask

  task automatic t_gpio();
    logic [31:0] d;
    gpio_in = 13'h1; settle();
    rd(3'd2, d); chk("R7 pin0", d, 32'h40);
    gpio_in = 13'h2; settle();
    rd(3'd2, d); chk("R7 pin1", d, 32'h80);
    gpio_in = 13'h4; settle();
    rd(3'd2, d); chk("R8 pin2", d, 32'h1 << 19);
    gpio_in = 13'h1000; settle();
    rd(3'd2, d); chk("R8 pin12", d, 32'h1 << 29);
    gpio_in = 0; src_in = (64'h1 << 20) | (64'h1 << 6); settle();
    rd(3'd2, d); chk("R8 periph ignored", d, 0);
    src_in = '0; settle();
  endtask

  task automatic t_unused();
    logic [31:0] d;
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd6, d); chk("R10 read6", d, 0);
    rd(3'd7, d); chk("R10 read7", d, 0);
    for (int a = 0; a < 5; a++) begin
      if (a != 2) begin
        rd(3'(a), d);
        chk("R10 regs untouched", d, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_steer();
    t_bank1();
    t_pending();
    t_gpio();
    t_unused();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule